// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Engine

This block is a memory-to-memory copy engine driven by a linked list of transfer descriptors kept in memory. Software builds the list, places the address of its first entry on `first_desc` and pulses `start`. The engine then works through the list on its own, one entry at a time. For each entry it reads the entry over a single-word memory master port, copies the segment the entry describes, writes a status word back into the entry and follows the entry's link to the next one. Data scattered over separate regions therefore moves as one logical job.

Completion is reported through a sticky `done` flag and a sticky `err` flag, plus a one-cycle interrupt pulse. Entries that ask for an interrupt are counted. The pulse fires when the count reaches a programmable threshold or when the list runs out, whichever comes first. This lets a long list raise far fewer interrupts than it has entries. Any error response from memory stops the list at once and always raises the pulse.

Top module: `sgdma_engine`

## Requirements
- R1: An entry occupies nine 32-bit words at byte offsets from its base: 0/4 source address low/high, 8/12 destination address low/high, 16 length in bytes, 20 control, 24/28 link low/high, 32 status. Before any data moves, the engine reads offsets 0 to 28 in ascending order, one read each.
- R2: The copy moves length[31:2] words, and length bits [1:0] are ignored. Each word is read from the source address and then written to the destination address, and both addresses rise by 4 per word. No destination word past the segment is written.
- R3: After the last data write of an entry, the engine writes the status word at offset 32. The value is 1 for a completed entry.
- R4: A link of zero ends the list. The engine drops `busy`, sets `done` and holds it until the next accepted start, and issues no memory request while idle. A non-zero link causes the entry at that address to be read next.
- R5: An entry whose word count is zero (length below 4) moves no data, but its status is still written as 1.
- R6: Control bit 0 marks an entry as interrupt-requesting. `irq` is a one-cycle pulse issued when the number of marked completions since the last pulse (or since start) reaches `coal_thresh`. A threshold of 0 acts as 1.
- R7: When the list ends with at least one marked completion not yet reported, `irq` pulses together with `done`. If none is pending, no pulse is issued.
- R8: A memory error response during an entry read, a data read or a data write makes the engine write status 2 into the current entry and stop. It then sets `err` (held until the next start), leaves `done` low, pulses `irq` regardless of the count, and touches no later entry.
- R9: `start` is ignored while `busy` is high. A start with `first_desc` equal to zero sets `done` at once, issues no memory access and no interrupt.
- R10: Once raised, `mem_req` with its `mem_addr`, `mem_we` and `mem_wdata` stays unchanged until the cycle in which `mem_ack` is high.
- R11: After reset, `busy`, `done`, `err`, `irq` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts the list walk |
| first_desc | input | 64 | Byte address of the first entry, 0 for an empty list |
| coal_thresh | input | CNT_W | Marked completions per interrupt pulse |
| busy | output | 1 | The list walk is in progress |
| done | output | 1 | The list ended normally (sticky) |
| err | output | 1 | The list stopped on an error (sticky) |
| irq | output | 1 | One-cycle interrupt pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle response that completes the request |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The hardest situation to reach is the one where the coalescing count and the end of the list interact. The threshold can be reached exactly at the last entry, or a partial count can be left over, or no entry is marked at all. Each case gives a different number of pulses, and each needs a particular mix of marks, lengths and thresholds. The stimulus builds many short random lists with random marks, zero and odd lengths, random thresholds and a randomly reversed placement in memory, while the memory model answers with random latency. Each run is compared against a predicted pulse count and an exact predicted access sequence. Directed lists add an error response placed in the middle of a list, an error on the very first entry read, and a start pulse issued while a list is running.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int ADDR_W      = 64;
  localparam int WORD_W      = 32;
  localparam int FETCH_WORDS = 8;
  localparam int IDX_W       = $clog2(FETCH_WORDS);
  localparam int STATUS_OFS  = 32;
  localparam logic [1:0] CODE_DONE = 2'd1;
  localparam logic [1:0] CODE_ERR  = 2'd2;
  localparam int CTL_IRQ_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_STATUS
  } walk_state_t;
endpackage

// File: rtl/sgdma_coal.sv
module sgdma_coal #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             evt,
  input  logic             evt_flag,
  input  logic             evt_last,
  input  logic             abort,
  input  logic [CNT_W-1:0] thresh,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_n;
  logic [CNT_W:0]   th_eff;

  assign cnt_n  = {1'b0, cnt} + {{CNT_W{1'b0}}, evt_flag};
  assign th_eff = (thresh == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, thresh};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (abort) begin
        irq <= 1'b1;
        cnt <= '0;
      end else if (evt) begin
        if (evt_flag && cnt_n >= th_eff) begin
          irq <= 1'b1;
          cnt <= '0;
        end else if (evt_last && cnt_n != '0) begin
          irq <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= cnt_n[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_desc,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              clr,
  output logic              evt,
  output logic              evt_flag,
  output logic              evt_last,
  output logic              abort
);
  walk_state_t       st;
  logic [ADDR_W-1:0] cur, src, dst, nxt;
  logic [WORD_W-1:0] len, ctl, hold;
  logic [WORD_W-3:0] rem;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        code;
  logic              stat_ack;

  assign busy     = (st != ST_IDLE);
  assign mem_req  = busy;
  assign mem_we   = (st == ST_WRITE) || (st == ST_STATUS);
  assign mem_wdata = (st == ST_STATUS) ? {{(WORD_W-2){1'b0}}, code} : hold;

  always_comb begin
    case (st)
      ST_FETCH:  mem_addr = cur + {{(ADDR_W-IDX_W-2){1'b0}}, idx, 2'b00};
      ST_READ:   mem_addr = src;
      ST_WRITE:  mem_addr = dst;
      ST_STATUS: mem_addr = cur + ADDR_W'(STATUS_OFS);
      default:   mem_addr = '0;
    endcase
  end

  assign stat_ack = (st == ST_STATUS) && mem_ack;
  assign clr      = (st == ST_IDLE) && start;
  assign abort    = stat_ack && (mem_err || code == CODE_ERR);
  assign evt      = stat_ack && !abort;
  assign evt_flag = ctl[CTL_IRQ_BIT];
  assign evt_last = (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; done <= 1'b0; err <= 1'b0; idx <= '0; code <= CODE_DONE;
      cur <= '0; src <= '0; dst <= '0; nxt <= '0; len <= '0; ctl <= '0;
      hold <= '0; rem <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          done <= 1'b0;
          err  <= 1'b0;
          idx  <= '0;
          if (first_desc == '0) done <= 1'b1;
          else begin
            cur <= first_desc;
            st  <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ack) begin
          if (mem_err) begin
            code <= CODE_ERR;
            st   <= ST_STATUS;
          end else begin
            case (idx)
              3'd0: src[31:0]  <= mem_rdata;
              3'd1: src[63:32] <= mem_rdata;
              3'd2: dst[31:0]  <= mem_rdata;
              3'd3: dst[63:32] <= mem_rdata;
              3'd4: len        <= mem_rdata;
              3'd5: ctl        <= mem_rdata;
              3'd6: nxt[31:0]  <= mem_rdata;
              default: nxt[63:32] <= mem_rdata;
            endcase
            idx <= idx + 1'b1;
            if (idx == IDX_W'(FETCH_WORDS - 1)) begin
              code <= CODE_DONE;
              rem  <= len[WORD_W-1:2];
              st   <= (len[WORD_W-1:2] == '0) ? ST_STATUS : ST_READ;
            end
          end
        end
        ST_READ: if (mem_ack) begin
          if (mem_err) begin
            code <= CODE_ERR;
            st   <= ST_STATUS;
          end else begin
            hold <= mem_rdata;
            st   <= ST_WRITE;
          end
        end
        ST_WRITE: if (mem_ack) begin
          if (mem_err) begin
            code <= CODE_ERR;
            st   <= ST_STATUS;
          end else begin
            src <= src + ADDR_W'(4);
            dst <= dst + ADDR_W'(4);
            rem <= rem - 1'b1;
            st  <= (rem == 1) ? ST_STATUS : ST_READ;
          end
        end
        ST_STATUS: if (mem_ack) begin
          if (mem_err || code == CODE_ERR) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else if (nxt == '0) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            cur <= nxt;
            idx <= '0;
            st  <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [63:0]      first_desc,
  input  logic [CNT_W-1:0] coal_thresh,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             irq,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata
);
  logic clr, evt, evt_flag, evt_last, abort;

  sgdma_walker u_walker (
    .clk(clk), .rst(rst), .start(start), .first_desc(first_desc),
    .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata),
    .clr(clr), .evt(evt), .evt_flag(evt_flag), .evt_last(evt_last),
    .abort(abort)
  );

  sgdma_coal #(.CNT_W(CNT_W)) u_coal (
    .clk(clk), .rst(rst), .clr(clr), .evt(evt), .evt_flag(evt_flag),
    .evt_last(evt_last), .abort(abort), .thresh(coal_thresh), .irq(irq)
  );
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        irq,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  assert_done_clean_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !err));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_err_irq_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> irq);
endmodule

bind sgdma_engine sgdma_engine_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err), .irq(irq),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sgdma_engine_tb.sv
module sgdma_engine_tb;
  localparam int CNT_W = 8;
  localparam int LOGN  = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [63:0] first_desc = '0;
  logic [CNT_W-1:0] coal_thresh = '0;
  logic busy, done, err, irq, mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic mem_ack, mem_err;

  always #2.5 clk = ~clk;

  sgdma_engine #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .first_desc(first_desc),
    .coal_thresh(coal_thresh), .busy(busy), .done(done), .err(err), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata)
  );

  // memory model: 16 KB of words, anything above is an error response
  logic [31:0] mem [0:4095];
  logic        log_we   [0:LOGN-1];
  logic [63:0] log_addr [0:LOGN-1];
  int log_n = 0;
  int irq_cnt = 0;
  int stab_bad = 0;
  int dly = 0;
  int cycles = 0;
  logic bad;
  logic p_req = 1'b0, p_ack = 1'b0;
  logic [63:0] p_addr = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
    if (p_req && !p_ack && (!mem_req || mem_addr != p_addr)) stab_bad <= stab_bad + 1;
    p_req <= mem_req; p_ack <= mem_ack; p_addr <= mem_addr;
    if (rst) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0; dly <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end else if (mem_req) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        bad = |mem_addr[63:14];
        mem_ack <= 1'b1;
        mem_err <= bad;
        mem_rdata <= bad ? 32'h0 : mem[mem_addr[13:2]];
        if (mem_we && !bad) mem[mem_addr[13:2]] <= mem_wdata;
        if (log_n < LOGN) begin
          log_we[log_n] <= mem_we; log_addr[log_n] <= mem_addr;
        end
        log_n <= log_n + 1;
        dly <= int'($urandom % 3);
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // chain description
  logic [63:0] ds_src [0:7];
  logic [63:0] ds_dst [0:7];
  logic [31:0] ds_len [0:7];
  logic        ds_flag[0:7];
  int          ds_slot[0:7];
  logic        exp_we   [0:1023];
  logic [63:0] exp_addr [0:1023];
  int exp_n;
  int log_base, irq_base;

  function automatic logic [63:0] slot_addr(input int s);
    return 64'(s) * 64'h40 + 64'h40;
  endfunction

  function automatic int pred_irqs(input int k, input int th);
    int cnt = 0, n = 0, t;
    t = (th == 0) ? 1 : th;
    for (int j = 0; j < k; j++)
      if (ds_flag[j]) begin
        cnt++;
        if (cnt >= t) begin n++; cnt = 0; end
      end
    if (cnt > 0) n++;
    return n;
  endfunction

  task automatic wr64(input logic [63:0] a, input logic [63:0] v);
    mem[a[13:2]] = v[31:0];
    mem[a[13:2] + 12'd1] = v[63:32];
  endtask

  task automatic setup_chain(input int k);
    for (int j = 0; j < k; j++) begin
      logic [63:0] b, nx;
      b  = slot_addr(ds_slot[j]);
      nx = (j == k - 1) ? 64'h0 : slot_addr(ds_slot[j+1]);
      wr64(b, ds_src[j]);
      wr64(b + 8, ds_dst[j]);
      mem[b[13:2] + 12'd4] = ds_len[j];
      mem[b[13:2] + 12'd5] = {$urandom} & 32'hFFFF_FFFE | {31'h0, ds_flag[j]};
      wr64(b + 24, nx);
      mem[b[13:2] + 12'd8] = 32'hDEAD_BEEF;
      for (int w = 0; w <= 9; w++) begin
        mem[ds_src[j][13:2] + 12'(w)] = $urandom;
        mem[ds_dst[j][13:2] + 12'(w)] = 32'h0;
      end
    end
  endtask

  task automatic push_exp(input logic we, input logic [63:0] a);
    exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_n++;
  endtask

  task automatic build_exp(input int k);
    exp_n = 0;
    for (int j = 0; j < k; j++) begin
      logic [63:0] b;
      b = slot_addr(ds_slot[j]);
      for (int w = 0; w < 8; w++) push_exp(1'b0, b + 64'(4 * w));
      for (int w = 0; w < int'(ds_len[j] >> 2); w++) begin
        push_exp(1'b0, ds_src[j] + 64'(4 * w));
        push_exp(1'b1, ds_dst[j] + 64'(4 * w));
      end
      push_exp(1'b1, b + 64'd32);
    end
  endtask

  task automatic run(input logic [63:0] fd, input int th, input bit poke);
    log_base = log_n; irq_base = irq_cnt;
    @(negedge clk);
    first_desc = fd; coal_thresh = CNT_W'(th); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      first_desc = slot_addr(7); start = 1'b1;   // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_chain(input int k, input int th, input string tag);
    int mis = -1;
    check(done === 1'b1 && err === 1'b0 && busy === 1'b0, {tag, " R4 done/err/busy"},
          {done, err, busy}, 3'b100);
    check(irq_cnt - irq_base == pred_irqs(k, th), {tag, " R6 R7 irq count"},
          irq_cnt - irq_base, pred_irqs(k, th));
    build_exp(k);
    for (int i = 0; i < exp_n; i++)
      if (mis < 0 && (log_we[log_base+i] !== exp_we[i] || log_addr[log_base+i] !== exp_addr[i]))
        mis = i;
    check(log_n - log_base == exp_n && mis < 0, {tag, " R1 R2 R3 access order"},
          (mis < 0) ? log_n - log_base : log_addr[log_base+mis],
          (mis < 0) ? exp_n : exp_addr[mis]);
    for (int j = 0; j < k; j++) begin
      logic [63:0] b;
      int nw, badw;
      b = slot_addr(ds_slot[j]);
      check(mem[b[13:2] + 12'd8] == 32'h1, {tag, " R3 R5 status"}, mem[b[13:2] + 12'd8], 1);
      nw = int'(ds_len[j] >> 2); badw = 0;
      for (int w = 0; w < nw; w++)
        if (mem[ds_dst[j][13:2] + 12'(w)] !== mem[ds_src[j][13:2] + 12'(w)]) badw++;
      check(badw == 0 && mem[ds_dst[j][13:2] + 12'(nw)] == 32'h0, {tag, " R2 data copy"},
            badw, 0);
    end
  endtask

  task automatic plain_chain(input int k);
    for (int j = 0; j < k; j++) begin
      ds_slot[j] = j;
      ds_src[j] = 64'h1000 + 64'(j) * 64'h80;
      ds_dst[j] = 64'h2000 + 64'(j) * 64'h80;
      ds_len[j] = 32'd8;
      ds_flag[j] = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, err, irq, mem_req} === 5'b0, "R11 reset state",
          {busy, done, err, irq, mem_req}, 0);

    // R9: empty list
    run(64'h0, 1, 1'b0);
    check(done === 1'b1 && log_n == log_base, "R9 zero first entry", log_n - log_base, 0);
    check(irq_cnt == irq_base, "R9 no irq on empty list", irq_cnt - irq_base, 0);

    // directed: lengths 8, 0, 14 in slots 0,2,1, all marked, threshold 2 (R5 R6 R7)
    ds_slot[0] = 0; ds_slot[1] = 2; ds_slot[2] = 1;
    for (int j = 0; j < 3; j++) begin
      ds_src[j] = 64'h1000 + 64'(j) * 64'h80;
      ds_dst[j] = 64'h2000 + 64'(j) * 64'h80;
      ds_flag[j] = 1'b1;
    end
    ds_len[0] = 32'd8; ds_len[1] = 32'd0; ds_len[2] = 32'd14;
    setup_chain(3);
    run(slot_addr(0), 2, 1'b1);
    check_chain(3, 2, "directed-A");
    check(irq_cnt - irq_base == 2, "R7 pending pulse at list end", irq_cnt - irq_base, 2);

    // directed: marks 1,0,1 threshold 0 acts as 1 (R6)
    plain_chain(3); ds_flag[0] = 1'b1; ds_flag[2] = 1'b1;
    setup_chain(3);
    run(slot_addr(0), 0, 1'b0);
    check(irq_cnt - irq_base == 2, "R6 threshold zero", irq_cnt - irq_base, 2);
    check_chain(3, 0, "directed-B");

    // directed: nothing marked -> no pulse (R7)
    plain_chain(2);
    setup_chain(2);
    run(slot_addr(0), 1, 1'b0);
    check(irq_cnt == irq_base, "R7 no pending no pulse", irq_cnt - irq_base, 0);

    // random lists
    for (int it = 0; it < 24; it++) begin
      int k, th;
      bit rev;
      k = 1 + int'($urandom % 4);
      th = int'($urandom % 4);
      rev = 1'($urandom);
      for (int j = 0; j < k; j++) begin
        ds_slot[j] = rev ? (k - 1 - j) : j;
        ds_src[j] = 64'h1000 + 64'(j) * 64'h80;
        ds_dst[j] = 64'h2000 + 64'(j) * 64'h80;
        ds_len[j] = $urandom % 36;
        ds_flag[j] = 1'($urandom);
      end
      setup_chain(k);
      run(slot_addr(ds_slot[0]), th, 1'b0);
      check_chain(k, th, $sformatf("random-%0d", it));
    end

    // R8: error on the source read of the second entry
    plain_chain(3); ds_flag[0] = 1'b1;
    setup_chain(3);
    mem[slot_addr(1) >> 2 & 64'hFFF] = 32'h0;
    mem[(slot_addr(1) >> 2) + 1] = 32'h1;   // source high word -> out of range
    run(slot_addr(0), 4, 1'b0);
    check(err === 1'b1 && done === 1'b0, "R8 err set, done low", {err, done}, 2'b10);
    check(mem[(slot_addr(0) >> 2) + 8] == 32'h1, "R8 earlier entry complete",
          mem[(slot_addr(0) >> 2) + 8], 1);
    check(mem[(slot_addr(1) >> 2) + 8] == 32'h2, "R8 error status written",
          mem[(slot_addr(1) >> 2) + 8], 2);
    check(mem[(slot_addr(2) >> 2) + 8] == 32'hDEAD_BEEF, "R8 later entry untouched",
          mem[(slot_addr(2) >> 2) + 8], 32'hDEAD_BEEF);
    check(irq_cnt - irq_base == 1, "R8 immediate irq despite threshold", irq_cnt - irq_base, 1);

    // R8: error on the very first entry read
    run(64'h2_0000_0000, 3, 1'b0);
    check(err === 1'b1 && done === 1'b0 && busy === 1'b0, "R8 fetch error stops",
          {err, done, busy}, 3'b100);
    check(irq_cnt - irq_base == 1, "R8 fetch error irq", irq_cnt - irq_base, 1);

    // recovery after error: err cleared by next start
    plain_chain(1); ds_flag[0] = 1'b1;
    setup_chain(1);
    run(slot_addr(0), 5, 1'b0);
    check_chain(1, 5, "after-error R8");

    check(stab_bad == 0, "R10 request held until ack", stab_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule